// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Bit Stop Timing

This block is a single-channel asynchronous serial transmitter. Software-side logic pushes bytes through a one-cycle write strobe into an eight-deep queue. A control unit takes each byte from the queue into a shift register and sends it on the serial line. Each frame is a low start bit, then eight data bits with the least significant bit first, then a high stop phase. Bit timing comes from an external enable that pulses at sixteen times the bit rate. One full bit lasts sixteen of those pulses.

The stop phase is set in sixteenths of a bit by a 4-bit code held in a small mode register. Two further mode bits enable flow control. The first holds back the start of each new character while the active-low clear-to-send input is high. The second makes the block drive an active-low request-to-send output around each burst of characters. Two status outputs report a free queue slot (ready) and a fully drained transmitter (empty).

Top module: `uart_frac_tx`

## Requirements
- R1: The serial line idles high. A frame is one low start bit, then eight data bits sent least significant bit first, and each bit lasts 16 `tickEn` pulses.
- R2: The stop phase lasts exactly N tick pulses. For `modeData[3:0]` codes 0 to 7, N is 9 plus the code (9 to 16). For codes 8 to 15, N is 17 plus the code (25 to 32). When another character is ready, its start bit follows the last stop tick with no idle gap.
- R3: The queue holds 8 characters. `txRdy` is high while at least one slot is free and low when all 8 are used. A write while the queue is full is dropped.
- R4: `txEmt` rises after the last stop tick of a character when the queue is empty. While `txEmt` is high the line is high.
- R5: `txEmt` is cleared in the cycle after a write strobe. It is also cleared in the cycle after `txEn` is low.
- R6: When `modeData[4]` (auto clear-to-send) is set, no new character starts while `ctsN` is high. A character already started is always completed.
- R7: When `modeData[4]` is clear, `ctsN` has no effect on transmission.
- R8: When `modeData[5]` (auto request-to-send) is set, `rtsN` goes low in the cycle after a byte is accepted into the queue. It goes high again only when a stop phase ends with the queue empty.
- R9: When `modeData[5]` is clear, `rtsN` is held high.
- R10: A `modeWr` pulse loads `modeData[5:0]` into the mode register. After reset the mode is all zero, so the default stop length is 9 ticks. After reset, `txd` and `rtsN` are high, `txRdy` is high and `txEmt` is low.
- R11: While `txEn` is low, no new character starts. A character already on the line is finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modeWr | input | 1 | Load strobe for the mode register |
| modeData | input | 6 | [3:0] stop code, [4] auto clear-to-send, [5] auto request-to-send |
| txEn | input | 1 | Transmitter enable level |
| tickEn | input | 1 | Enable pulse at 16 times the bit rate |
| wrStb | input | 1 | Queue write strobe |
| wrData | input | DATA_W | Byte to queue |
| ctsN | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial line |
| rtsN | output | 1 | Request-to-send, active low |
| txRdy | output | 1 | Queue has a free slot |
| txEmt | output | 1 | Queue and shifter both drained |

## Verification
The bench uses the default parameters: an 8-deep queue and 16 ticks per bit. With these values a full queue and the dropped ninth write can be reached in a few hundred cycles, and so can every stop code up to the 32-tick maximum. With `tickEn` high on every cycle, each stop length can be measured to the exact cycle as the high run between two frames sent back to back. A second pass pulses `tickEn` on every other cycle, which shows that timing counts only tick pulses and not clock cycles.

// File: rtl/uart_frac_tx_pkg.sv
package uart_frac_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } txState_e;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA
  } lineSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     pop;
    logic     shift;
    lineSel_e lineSel;
  } txStrobes_t;

  // stop length in ticks: half a bit plus one sixteenth plus the low code bits,
  // with a full extra bit when the top code bit is set
  function automatic int unsigned stopTicks(input logic [3:0] code,
                                            input int unsigned ticksPerBit);
    int unsigned extra;
    extra = code[3] ? ticksPerBit : 32'd0;
    return extra + ticksPerBit / 2 + 32'd1 + 32'(code[2:0]);
  endfunction

endpackage

// File: rtl/txDatapath.sv
module txDatapath
  import uart_frac_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobes_t        strobes,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              txd
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  logic [DATA_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fillCnt;
  logic [DATA_W-1:0] shReg;
  logic              push, pop;

  assign fifoEmpty = (fillCnt == '0);
  assign fifoFull  = (fillCnt == CNT_W'(FIFO_DEPTH));
  assign push      = wrStb && !fifoFull;
  assign pop       = strobes.pop && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (push) fifoMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             shReg <= '0;
    else if (pop)           shReg <= fifoMem[rdPtr];
    else if (strobes.shift) shReg <= shReg >> 1;
  end

  always_comb begin
    case (strobes.lineSel)
      LINE_SPACE: txd = 1'b0;
      LINE_DATA:  txd = shReg[0];
      default:    txd = 1'b1;
    endcase
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fillCnt <= CNT_W'(FIFO_DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoFull && !strobes.pop) |=> $stable(fillCnt));

  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.pop |-> !fifoEmpty);

endmodule

// File: rtl/txControl.sv
module txControl
  import uart_frac_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic       txEn,
  input  logic       ctsN,
  input  logic       modeWr,
  input  logic [5:0] modeData,
  input  logic       wrStb,
  input  logic       fifoEmpty,
  input  logic       fifoFull,
  output txStrobes_t strobes,
  output logic       rtsN,
  output logic       txEmt
);

  localparam int TCNT_W = $clog2(2 * TICKS_PER_BIT + 1);
  localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [TCNT_W-1:0] LAST_TICK = TCNT_W'(TICKS_PER_BIT - 1);

  txState_e          state;
  logic [TCNT_W-1:0] tickCnt;
  logic [TCNT_W-1:0] stopLen;
  logic [BIT_W-1:0]  bitIdx;
  logic [3:0]        stopCode;
  logic              autoCts, autoRts;
  logic              canStart, lastBitTick, lastStopTick, frameDone, push;

  // mode register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopCode <= '0;
      autoCts  <= 1'b0;
      autoRts  <= 1'b0;
    end else if (modeWr) begin
      stopCode <= modeData[3:0];
      autoCts  <= modeData[4];
      autoRts  <= modeData[5];
    end
  end

  assign canStart     = !fifoEmpty && txEn && !(autoCts && ctsN);
  assign lastBitTick  = tickEn && (tickCnt == LAST_TICK);
  assign lastStopTick = tickEn && (tickCnt == stopLen - 1'b1);
  assign frameDone    = (state == ST_STOP) && lastStopTick;
  assign push         = wrStb && !fifoFull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      stopLen <= TCNT_W'(stopTicks(4'd0, TICKS_PER_BIT));
    end else begin
      case (state)
        ST_IDLE: begin
          if (canStart) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (lastBitTick) begin
            state   <= ST_DATA;
            tickCnt <= '0;
            bitIdx  <= '0;
          end else if (tickEn) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (lastBitTick) begin
            tickCnt <= '0;
            if (bitIdx == LAST_BIT) begin
              state   <= ST_STOP;
              stopLen <= TCNT_W'(stopTicks(stopCode, TICKS_PER_BIT));
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else if (tickEn) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (lastStopTick) begin
            tickCnt <= '0;
            state   <= canStart ? ST_START : ST_IDLE;
          end else if (tickEn) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.pop   = ((state == ST_IDLE) || frameDone) && canStart;
    strobes.shift = (state == ST_DATA) && lastBitTick;
    case (state)
      ST_START: strobes.lineSel = LINE_SPACE;
      ST_DATA:  strobes.lineSel = LINE_DATA;
      default:  strobes.lineSel = LINE_MARK;
    endcase
  end

  // drained flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       txEmt <= 1'b0;
    else if (wrStb || !txEn)          txEmt <= 1'b0;
    else if (frameDone && fifoEmpty)  txEmt <= 1'b1;
  end

  // request-to-send handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rtsN <= 1'b1;
    else if (!autoRts)               rtsN <= 1'b1;
    else if (push)                   rtsN <= 1'b0;
    else if (frameDone && fifoEmpty) rtsN <= 1'b1;
  end

  p_stop_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> (tickCnt < stopLen));

  p_cts_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && autoCts && ctsN) |=> (state == ST_IDLE));

  p_cts_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frameDone && autoCts && ctsN) |=> (state == ST_IDLE));

  p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !txEn) |=> (state == ST_IDLE));

  p_emt_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrStb |=> !txEmt);

  p_emt_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !txEn |=> !txEmt);

  p_rts_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !autoRts |=> rtsN);

  p_rts_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (autoRts && push) |=> !rtsN);

endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
  import uart_frac_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeWr,
  input  logic [5:0]        modeData,
  input  logic              txEn,
  input  logic              tickEn,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ctsN,
  output logic              txd,
  output logic              rtsN,
  output logic              txRdy,
  output logic              txEmt
);

  txStrobes_t strobes;
  logic       fifoEmpty, fifoFull;

  txControl #(
    .DATA_W        (DATA_W),
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) i_txControl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tickEn    (tickEn),
    .txEn      (txEn),
    .ctsN      (ctsN),
    .modeWr    (modeWr),
    .modeData  (modeData),
    .wrStb     (wrStb),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .strobes   (strobes),
    .rtsN      (rtsN),
    .txEmt     (txEmt)
  );

  txDatapath #(
    .DATA_W     (DATA_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) i_txDatapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrStb     (wrStb),
    .wrData    (wrData),
    .strobes   (strobes),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .txd       (txd)
  );

  assign txRdy = !fifoFull;

  p_idle_when_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txEmt |-> txd);

endmodule

// File: tb/test_uart_frac_tx.sv
`timescale 1ns/1ps
module test_uart_frac_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       modeWr = 1'b0;
  logic [5:0] modeData = '0;
  logic       txEn = 1'b0;
  logic       tickEn = 1'b1;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic       ctsN = 1'b0;
  logic       txd, rtsN, txRdy, txEmt;

  int checks = 0;
  int fails  = 0;
  int tickDiv = 1;
  int tickPhase = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tickPhase = tickPhase + 1;
    tickEn = (tickDiv <= 1) || ((tickPhase % tickDiv) == 0);
  end

  uart_frac_tx i_uart_frac_tx (
    .clk(clk), .rst_n(rst_n), .modeWr(modeWr), .modeData(modeData),
    .txEn(txEn), .tickEn(tickEn), .wrStb(wrStb), .wrData(wrData),
    .ctsN(ctsN), .txd(txd), .rtsN(rtsN), .txRdy(txRdy), .txEmt(txEmt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    txEn = 1'b0; wrStb = 1'b0; modeWr = 1'b0; ctsN = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] b);
    wrStb = 1'b1; wrData = b;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic setMode(input logic [3:0] code, input bit cts, input bit rts);
    modeWr = 1'b1; modeData = {rts, cts, code};
    @(negedge clk);
    modeWr = 1'b0;
  endtask

  // capture one frame; run = high cycles after the data bits (capped at 200)
  task automatic captureFrame(input int div, output logic [7:0] d, output int run);
    int waitCnt;
    waitCnt = 0; d = '0; run = 0;
    while (txd !== 1'b0 && waitCnt < 3000) begin
      @(negedge clk); waitCnt++;
    end
    check(waitCnt < 3000, "R1", "frame start seen", waitCnt, 0);
    if (waitCnt >= 3000) return;
    repeat (8 * div) @(negedge clk);
    check(txd === 1'b0, "R1", "start bit low", int'(txd), 0);
    for (int k = 0; k < 8; k++) begin
      repeat (16 * div) @(negedge clk);
      d[k] = txd;
    end
    repeat (8 * div) @(negedge clk);
    while (txd === 1'b1 && run < 200) begin
      run++; @(negedge clk);
    end
  endtask

  task automatic testReset();
    doReset();
    check(txd === 1'b1,  "R10", "txd after reset",   int'(txd),   1);
    check(rtsN === 1'b1, "R10", "rtsN after reset",  int'(rtsN),  1);
    check(txRdy === 1'b1,"R10", "txRdy after reset", int'(txRdy), 1);
    check(txEmt === 1'b0,"R10", "txEmt after reset", int'(txEmt), 0);
  endtask

  task automatic testFraming();
    logic [7:0] d; int run;
    doReset();
    txEn = 1'b1;
    writeByte(8'hA5);
    writeByte(8'h3C);
    captureFrame(1, d, run);
    check(d == 8'hA5, "R1", "first byte", d, 8'hA5);
    check(run == 9, "R10", "default stop ticks", run, 9);
    captureFrame(1, d, run);
    check(d == 8'h3C, "R1", "second byte", d, 8'h3C);
    check(txEmt === 1'b1, "R4", "txEmt after drain", int'(txEmt), 1);
  endtask

  task automatic testStopCodes();
    logic [7:0] d; int run; int exp;
    logic [3:0] codes [4] = '{4'd0, 4'd7, 4'd8, 4'd15};
    doReset();
    txEn = 1'b1;
    foreach (codes[i]) begin
      setMode(codes[i], 1'b0, 1'b0);
      exp = (codes[i] < 8) ? 9 + int'(codes[i]) : 17 + int'(codes[i]);
      writeByte(8'h5A + 8'(i));
      writeByte(8'hC3);
      captureFrame(1, d, run);
      check(run == exp, "R2", $sformatf("stop ticks code %0d", codes[i]), run, exp);
      check(d == 8'h5A + 8'(i), "R2", "byte before stop", d, 8'h5A + i);
      captureFrame(1, d, run);
    end
  endtask

  task automatic testFifoFull();
    logic [7:0] d; int run;
    doReset();
    for (int i = 0; i < 7; i++) writeByte(8'h10 + 8'(i));
    check(txRdy === 1'b1, "R3", "txRdy with 7 queued", int'(txRdy), 1);
    writeByte(8'h17);
    check(txRdy === 1'b0, "R3", "txRdy with 8 queued", int'(txRdy), 0);
    writeByte(8'hEE);
    txEn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      captureFrame(1, d, run);
      check(d == 8'h10 + 8'(i), "R3", $sformatf("queued byte %0d", i), d, 8'h10 + i);
    end
    check(run >= 200, "R3", "no ninth frame", run, 200);
    check(txEmt === 1'b1, "R4", "txEmt after full drain", int'(txEmt), 1);
  endtask

  task automatic testEmtClear();
    logic [7:0] d; int run;
    writeByte(8'h81);
    check(txEmt === 1'b0, "R5", "txEmt after write", int'(txEmt), 0);
    captureFrame(1, d, run);
    check(txEmt === 1'b1, "R4", "txEmt set again", int'(txEmt), 1);
    txEn = 1'b0;
    @(negedge clk);
    check(txEmt === 1'b0, "R5", "txEmt after disable", int'(txEmt), 0);
  endtask

  task automatic testDisable();
    logic [7:0] d; int run; bit sawLow;
    doReset();
    writeByte(8'h96);
    sawLow = 1'b0;
    repeat (300) begin @(negedge clk); if (txd !== 1'b1) sawLow = 1'b1; end
    check(!sawLow, "R11", "line idle while disabled", int'(sawLow), 0);
    txEn = 1'b1;
    captureFrame(1, d, run);
    check(d == 8'h96, "R11", "byte after enable", d, 8'h96);
    writeByte(8'h4B);
    writeByte(8'hD2);
    fork
      captureFrame(1, d, run);
      begin repeat (40) @(negedge clk); txEn = 1'b0; end
    join
    check(d == 8'h4B, "R11", "frame completes after disable", d, 8'h4B);
    check(run >= 200, "R11", "no start while disabled", run, 200);
    txEn = 1'b1;
    captureFrame(1, d, run);
    check(d == 8'hD2, "R11", "held byte sent", d, 8'hD2);
  endtask

  task automatic testAutoCts();
    logic [7:0] d; int run; bit sawLow;
    doReset();
    setMode(4'd0, 1'b1, 1'b0);
    ctsN = 1'b1; txEn = 1'b1;
    writeByte(8'h69);
    sawLow = 1'b0;
    repeat (100) begin @(negedge clk); if (txd !== 1'b1) sawLow = 1'b1; end
    check(!sawLow, "R6", "start deferred by ctsN", int'(sawLow), 0);
    ctsN = 1'b0;
    captureFrame(1, d, run);
    check(d == 8'h69, "R6", "byte after cts", d, 8'h69);
    writeByte(8'h33);
    writeByte(8'hCC);
    fork
      captureFrame(1, d, run);
      begin repeat (40) @(negedge clk); ctsN = 1'b1; end
    join
    check(d == 8'h33, "R6", "in-progress frame completes", d, 8'h33);
    check(run >= 200, "R6", "next frame held", run, 200);
    ctsN = 1'b0;
    captureFrame(1, d, run);
    check(d == 8'hCC, "R6", "held byte after cts", d, 8'hCC);
  endtask

  task automatic testCtsIgnored();
    logic [7:0] d; int run;
    doReset();
    ctsN = 1'b1; txEn = 1'b1;
    writeByte(8'hE1);
    captureFrame(1, d, run);
    check(d == 8'hE1, "R7", "ctsN ignored", d, 8'hE1);
    ctsN = 1'b0;
  endtask

  task automatic testAutoRts();
    logic [7:0] d; int run;
    doReset();
    setMode(4'd0, 1'b0, 1'b1);
    check(rtsN === 1'b1, "R8", "rtsN idle", int'(rtsN), 1);
    txEn = 1'b1;
    writeByte(8'h71);
    check(rtsN === 1'b0, "R8", "rtsN after load", int'(rtsN), 0);
    writeByte(8'h17);
    captureFrame(1, d, run);
    check(rtsN === 1'b0, "R8", "rtsN between frames", int'(rtsN), 0);
    captureFrame(1, d, run);
    check(d == 8'h17, "R8", "second byte", d, 8'h17);
    check(rtsN === 1'b1, "R8", "rtsN released", int'(rtsN), 1);
  endtask

  task automatic testRtsOff();
    logic [7:0] d; int run;
    doReset();
    txEn = 1'b1;
    writeByte(8'h0F);
    check(rtsN === 1'b1, "R9", "rtsN after write", int'(rtsN), 1);
    captureFrame(1, d, run);
    check(rtsN === 1'b1, "R9", "rtsN after frame", int'(rtsN), 1);
  endtask

  task automatic testSlowTick();
    logic [7:0] d; int run;
    doReset();
    tickDiv = 2;
    txEn = 1'b1;
    writeByte(8'hB4);
    captureFrame(2, d, run);
    check(d == 8'hB4, "R1", "byte with half-rate ticks", d, 8'hB4);
    tickDiv = 1;
  endtask

  initial begin
    testReset();
    testFraming();
    testStopCodes();
    testFifoFull();
    testEmtClear();
    testDisable();
    testAutoCts();
    testCtsIgnored();
    testAutoRts();
    testRtsOff();
    testSlowTick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule